// File: doc/BRIEF.md
# Segment and Bypass Address Translator

This block is the first stage of a 32-bit address translation path. For each access it picks one of three routes. If translation is switched off in the global configuration word, the address passes through unchanged. If the access is from kernel mode and its segment is enabled, a fixed segment mapping applies. Every other access is sent on to a page translation buffer, which is a separate block.

A segment mapping replaces the top four address bits with a 4-bit base for that segment. The sixteen bases are packed eight to a register across two 32-bit base registers. When a page lookup is needed, the block also says which buffer to use: instruction fetches go to the instruction buffer, and loads and stores go to the data buffer.

All outputs are registered. The result for the inputs present at one rising clock edge appears right after that edge. There is no other internal state.

Top module: `xlat_front`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `paddr`=0, `perm`=0, `page_lookup`=0 and `use_ibuf`=0.
- R2: Translation is on when `glob_cfg[3:2]` is not 2'b00. When it is off: `paddr` equals `vaddr`, `perm` is 3'b111, `page_lookup` is 0 and `use_ibuf` is 0. This holds for any access kind or mode.
- R3: The segment number is `vaddr[31:28]`. With translation on, an access is segment-mapped only when `user_mode`=0 and `seg_en[segment]`=1.
- R4: For a segment-mapped access, `paddr` is {nibble, `vaddr[27:0]`} and `perm` is 3'b111. Segments 0 to 7 take the nibble from `seg_base_lo` and segments 8 to 15 from `seg_base_hi`. For segment s, the nibble sits at bits [4k+3:4k] with k = s mod 8.
- R5: A user-mode access never takes the segment route, even when its enable bit is set. It needs a page lookup.
- R6: A page-lookup access sets `page_lookup`=1, with `perm`=3'b000 and `paddr`=0. The permission bits are bit0 read, bit1 write and bit2 execute.
- R7: `acc_kind` is encoded 0 read, 1 write, 2 execute, and code 3 is handled as a read. `use_ibuf` is 1 only for a page-lookup access with `acc_kind`=2. Otherwise it is 0.
- R8: Each output reflects the inputs sampled at the previous rising edge, a latency of exactly one cycle.
- R9: `perm` is never nonzero while `page_lookup` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vaddr | input | 32 | Virtual address |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 as read |
| user_mode | input | 1 | 1 for a user-mode access, 0 for kernel |
| glob_cfg | input | 32 | Global configuration; bits 3:2 enable translation |
| seg_en | input | 16 | Per-segment enable mask for direct mapping |
| seg_base_lo | input | 32 | Base nibbles for segments 0 to 7 |
| seg_base_hi | input | 32 | Base nibbles for segments 8 to 15 |
| paddr | output | 32 | Physical address (registered) |
| perm | output | 3 | Granted permissions: bit0 read, bit1 write, bit2 execute |
| page_lookup | output | 1 | Access must be resolved by the page buffer |
| use_ibuf | output | 1 | Page lookup targets the instruction buffer |

## Verification
The only state is the output register stage. A wrong route decision therefore shows at the ports one cycle after the offending inputs and lasts for exactly one result. The scoreboard compares every cycle's result against an independent model. Any wrongly chosen segment nibble, stale value or mixed-up buffer select is caught at its first occurrence. Segments at both ends of each base register are driven on purpose, because an off-by-one in nibble selection only shows there.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ROUTE_BYPASS = 2'd0,
    ROUTE_SEG    = 2'd1,
    ROUTE_PAGE   = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    ACC_RD   = 2'd0,
    ACC_WR   = 2'd1,
    ACC_EX   = 2'd2,
    ACC_RSVD = 2'd3
  } acc_e;

  localparam int PERM_W = 3;
  localparam logic [PERM_W-1:0] PERM_ALL  = 3'b111;
  localparam logic [PERM_W-1:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/xlat_route_decode.sv
module xlat_route_decode
  import xlat_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int CFG_W  = 32,
  parameter int EN_LSB = 2,
  parameter int EN_W   = 2
) (
  input  logic [SEG_W-1:0]        seg,
  input  logic [1:0]              acc_kind,
  input  logic                    user_mode,
  input  logic [CFG_W-1:0]        glob_cfg,
  input  logic [(1<<SEG_W)-1:0]   seg_en,
  output route_e                  route,
  output logic                    to_ibuf
);
  localparam logic [CFG_W-1:0] EN_MASK = ((CFG_W'(1) << EN_W) - CFG_W'(1)) << EN_LSB;

  logic xlat_on;
  logic seg_hit;
  logic unused_cfg_bits;

  assign xlat_on         = |(glob_cfg & EN_MASK);
  assign unused_cfg_bits = ^(glob_cfg & ~EN_MASK);
  assign seg_hit         = !user_mode && seg_en[seg];

  always_comb begin
    if (!xlat_on)     route = ROUTE_BYPASS;
    else if (seg_hit) route = ROUTE_SEG;
    else              route = ROUTE_PAGE;
  end

  // Only execute goes to the instruction buffer; the reserved code acts as a read.
  assign to_ibuf = (route == ROUTE_PAGE) && (acc_kind == ACC_EX);

endmodule

// File: rtl/xlat_seg_base.sv
module xlat_seg_base #(
  parameter int SEG_W  = 4,
  parameter int BASE_W = 32
) (
  input  logic [BASE_W-1:0] base_lo,
  input  logic [BASE_W-1:0] base_hi,
  input  logic [SEG_W-1:0]  seg,
  output logic [SEG_W-1:0]  nibble
);
  localparam int SEG_CNT = 1 << SEG_W;
  localparam int HALF    = SEG_CNT / 2;

  logic [SEG_W-1:0] nib_tab [SEG_CNT];

  generate
    for (genvar g = 0; g < HALF; g++) begin : g_slot
      assign nib_tab[g]        = base_lo[g*SEG_W +: SEG_W];
      assign nib_tab[g + HALF] = base_hi[g*SEG_W +: SEG_W];
    end
  endgenerate

  assign nibble = nib_tab[seg];

endmodule

// File: rtl/xlat_out_reg.sv
module xlat_out_reg
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] paddr_d,
  input  logic [PERM_W-1:0] perm_d,
  input  logic              lookup_d,
  input  logic              ibuf_d,
  output logic [ADDR_W-1:0] paddr_q,
  output logic [PERM_W-1:0] perm_q,
  output logic              lookup_q,
  output logic              ibuf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      paddr_q  <= '0;
      perm_q   <= PERM_NONE;
      lookup_q <= 1'b0;
      ibuf_q   <= 1'b0;
    end else begin
      paddr_q  <= paddr_d;
      perm_q   <= perm_d;
      lookup_q <= lookup_d;
      ibuf_q   <= ibuf_d;
    end
  end
endmodule

// File: rtl/xlat_front.sv
module xlat_front
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int CFG_W  = 32,
  parameter int EN_LSB = 2,
  parameter int EN_W   = 2,
  parameter int BASE_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     vaddr,
  input  logic [1:0]            acc_kind,
  input  logic                  user_mode,
  input  logic [CFG_W-1:0]      glob_cfg,
  input  logic [(1<<SEG_W)-1:0] seg_en,
  input  logic [BASE_W-1:0]     seg_base_lo,
  input  logic [BASE_W-1:0]     seg_base_hi,
  output logic [ADDR_W-1:0]     paddr,
  output logic [PERM_W-1:0]     perm,
  output logic                  page_lookup,
  output logic                  use_ibuf
);
  localparam int OFF_W = ADDR_W - SEG_W;

  logic [SEG_W-1:0]  seg;
  logic [SEG_W-1:0]  base_nib;
  route_e            route;
  logic              to_ibuf;
  logic [ADDR_W-1:0] paddr_d;
  logic [PERM_W-1:0] perm_d;
  logic              lookup_d;

  assign seg = vaddr[ADDR_W-1 -: SEG_W];

  xlat_route_decode #(
    .SEG_W (SEG_W),
    .CFG_W (CFG_W),
    .EN_LSB(EN_LSB),
    .EN_W  (EN_W)
  ) u_decode (
    .seg      (seg),
    .acc_kind (acc_kind),
    .user_mode(user_mode),
    .glob_cfg (glob_cfg),
    .seg_en   (seg_en),
    .route    (route),
    .to_ibuf  (to_ibuf)
  );

  xlat_seg_base #(
    .SEG_W (SEG_W),
    .BASE_W(BASE_W)
  ) u_base (
    .base_lo(seg_base_lo),
    .base_hi(seg_base_hi),
    .seg    (seg),
    .nibble (base_nib)
  );

  always_comb begin
    paddr_d  = '0;
    perm_d   = PERM_NONE;
    lookup_d = 1'b0;
    unique case (route)
      ROUTE_BYPASS: begin
        paddr_d = vaddr;
        perm_d  = PERM_ALL;
      end
      ROUTE_SEG: begin
        paddr_d = {base_nib, vaddr[OFF_W-1:0]};
        perm_d  = PERM_ALL;
      end
      default: lookup_d = 1'b1;
    endcase
  end

  xlat_out_reg #(
    .ADDR_W(ADDR_W)
  ) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .paddr_d (paddr_d),
    .perm_d  (perm_d),
    .lookup_d(lookup_d),
    .ibuf_d  (to_ibuf),
    .paddr_q (paddr),
    .perm_q  (perm),
    .lookup_q(page_lookup),
    .ibuf_q  (use_ibuf)
  );

endmodule

// File: rtl/xlat_front_chk.sv
module xlat_front_chk #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int CFG_W  = 32,
  parameter int EN_LSB = 2,
  parameter int EN_W   = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     vaddr,
  input logic [1:0]            acc_kind,
  input logic                  user_mode,
  input logic [CFG_W-1:0]      glob_cfg,
  input logic [(1<<SEG_W)-1:0] seg_en,
  input logic [ADDR_W-1:0]     paddr,
  input logic [2:0]            perm,
  input logic                  page_lookup,
  input logic                  use_ibuf
);
  localparam int OFF_W = ADDR_W - SEG_W;

  logic cfg_on;
  assign cfg_on = glob_cfg[EN_LSB +: EN_W] != '0;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (paddr == '0 && perm == 3'b000 && !page_lookup && !use_ibuf));

  assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_on |=> (paddr == $past(vaddr) && perm == 3'b111 && !page_lookup && !use_ibuf));

  assert_seg_offset_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && !user_mode && seg_en[vaddr[ADDR_W-1 -: SEG_W]])
      |=> (paddr[OFF_W-1:0] == $past(vaddr[OFF_W-1:0]) && perm == 3'b111 && !page_lookup));

  assert_user_no_seg_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && user_mode) |=> page_lookup);

  assert_ibuf_exec_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && user_mode) |=> (use_ibuf == ($past(acc_kind) == 2'd2)));

  assert_ibuf_needs_lookup_R7: assert property (@(posedge clk) disable iff (rst)
    use_ibuf |-> page_lookup);

  assert_lookup_no_perm_R9: assert property (@(posedge clk) disable iff (rst)
    page_lookup |-> (perm == 3'b000 && paddr == '0));

endmodule

bind xlat_front xlat_front_chk #(
  .ADDR_W(ADDR_W),
  .SEG_W (SEG_W),
  .CFG_W (CFG_W),
  .EN_LSB(EN_LSB),
  .EN_W  (EN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .vaddr      (vaddr),
  .acc_kind   (acc_kind),
  .user_mode  (user_mode),
  .glob_cfg   (glob_cfg),
  .seg_en     (seg_en),
  .paddr      (paddr),
  .perm       (perm),
  .page_lookup(page_lookup),
  .use_ibuf   (use_ibuf)
);

// File: tb/xlat_front_tb.sv
module xlat_front_tb;

  typedef struct {
    logic [31:0] paddr;
    logic [2:0]  perm;
    logic        lookup;
    logic        ibuf;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] vaddr = '0;
  logic [1:0]  acc_kind = '0;
  logic        user_mode = 1'b0;
  logic [31:0] glob_cfg = '0;
  logic [15:0] seg_en = '0;
  logic [31:0] seg_base_lo = '0;
  logic [31:0] seg_base_hi = '0;
  logic [31:0] paddr;
  logic [2:0]  perm;
  logic        page_lookup;
  logic        use_ibuf;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  exp_t exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  xlat_front u_dut (
    .clk(clk), .rst(rst), .vaddr(vaddr), .acc_kind(acc_kind),
    .user_mode(user_mode), .glob_cfg(glob_cfg), .seg_en(seg_en),
    .seg_base_lo(seg_base_lo), .seg_base_hi(seg_base_hi),
    .paddr(paddr), .perm(perm), .page_lookup(page_lookup), .use_ibuf(use_ibuf)
  );

  function automatic exp_t model(logic [31:0] va, logic [1:0] k, logic um,
                                 logic [31:0] cfg, logic [15:0] en,
                                 logic [31:0] lo, logic [31:0] hi);
    exp_t e;
    int s;
    logic [3:0] nib;
    s = int'(va[31:28]);
    e.paddr = '0; e.perm = 3'b000; e.lookup = 1'b0; e.ibuf = 1'b0;
    if (cfg[3:2] == 2'b00) begin
      e.paddr = va; e.perm = 3'b111; e.req = "R2";
    end else if (!um && en[s]) begin
      nib = (s < 8) ? lo[(s%8)*4 +: 4] : hi[(s%8)*4 +: 4];
      e.paddr = {nib, va[27:0]}; e.perm = 3'b111; e.req = "R3/R4";
    end else begin
      e.lookup = 1'b1; e.ibuf = (k == 2'd2);
      e.req = um ? "R5/R6/R7" : "R6/R7";
    end
    return e;
  endfunction

  task automatic drive(logic [31:0] va, logic [1:0] k, logic um, logic [31:0] cfg,
                       logic [15:0] en, logic [31:0] lo, logic [31:0] hi);
    @(negedge clk);
    vaddr = va; acc_kind = k; user_mode = um; glob_cfg = cfg;
    seg_en = en; seg_base_lo = lo; seg_base_hi = hi;
    exp_q.push_back(model(va, k, um, cfg, en, lo, hi));
  endtask

  // Monitor: result of the inputs registered at this edge (R8 one-cycle latency)
  always @(posedge clk) begin
    #2;
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (paddr !== e.paddr || perm !== e.perm || page_lookup !== e.lookup || use_ibuf !== e.ibuf) begin
        n_fail++;
        $display("FAIL %s/R8/R9: got paddr=%h perm=%b lk=%b ib=%b exp paddr=%h perm=%b lk=%b ib=%b",
                 e.req, paddr, perm, page_lookup, use_ibuf, e.paddr, e.perm, e.lookup, e.ibuf);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsr;
    logic [31:0] lo_pat;
    logic [31:0] hi_pat;
    lo_pat = 32'h7654_3A9C;
    hi_pat = 32'hE1D2_C3B5;
    vaddr = 32'hDEAD_BEEF; glob_cfg = 32'h4; seg_en = 16'hFFFF;
    repeat (3) @(posedge clk);
    #2;
    n_checks++;  // R1 reset state
    if (paddr !== '0 || perm !== 3'b000 || page_lookup !== 1'b0 || use_ibuf !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got paddr=%h perm=%b lk=%b ib=%b expected all zero",
               paddr, perm, page_lookup, use_ibuf);
    end
    @(negedge clk); rst = 1'b0;

    // R2 bypass, different kinds and modes, other cfg bits set
    drive(32'h1234_5678, 2'd0, 1'b0, 32'hFFFF_FFF3, 16'hFFFF, lo_pat, hi_pat);
    drive(32'hF000_0001, 2'd2, 1'b1, 32'h0, 16'h0, lo_pat, hi_pat);
    drive(32'h8ABC_DEF0, 2'd1, 1'b1, 32'h0000_0010, 16'hFFFF, lo_pat, hi_pat);
    // R3/R4 segment mapping at both ends of each base register, cfg bit2 only and bit3 only
    drive(32'h0111_2222, 2'd0, 1'b0, 32'h4, 16'hFFFF, lo_pat, hi_pat);
    drive(32'h7ABC_0123, 2'd1, 1'b0, 32'h8, 16'hFFFF, lo_pat, hi_pat);
    drive(32'h8FFF_FFFF, 2'd2, 1'b0, 32'hC, 16'hFFFF, lo_pat, hi_pat);
    drive(32'hF000_0000, 2'd3, 1'b0, 32'h4, 16'hFFFF, lo_pat, hi_pat);
    drive(32'h3055_AA00, 2'd2, 1'b0, 32'h4, 16'h0008, lo_pat, hi_pat);
    drive(32'hC055_AA00, 2'd0, 1'b0, 32'h8, 16'h1000, lo_pat, hi_pat);
    // R3: enable bit clear for this segment -> lookup
    drive(32'h3055_AA00, 2'd0, 1'b0, 32'h4, 16'hFFF7, lo_pat, hi_pat);
    // R5 user mode with enable set
    drive(32'h0000_1000, 2'd0, 1'b1, 32'h4, 16'hFFFF, lo_pat, hi_pat);
    drive(32'hC000_1000, 2'd2, 1'b1, 32'h8, 16'hFFFF, lo_pat, hi_pat);
    // R6/R7 buffer select per access kind
    drive(32'h5000_2000, 2'd2, 1'b0, 32'h4, 16'h0, lo_pat, hi_pat);
    drive(32'h5000_2000, 2'd1, 1'b0, 32'h4, 16'h0, lo_pat, hi_pat);
    drive(32'h5000_2000, 2'd3, 1'b0, 32'h4, 16'h0, lo_pat, hi_pat);
    drive(32'h5000_2000, 2'd0, 1'b0, 32'h4, 16'h0, lo_pat, hi_pat);

    // Mixed patterns, back to back
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b, c;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; b = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; c = lfsr;
      drive(a, b[1:0], b[2], {b[31:4], (b[5:4] == 2'b00) ? 2'b00 : b[3:2], b[1:0]},
            c[15:0], c ^ a, b ^ c);
    end

    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule